// File: doc/BRIEF.md
# Endpoint-Zero Control-Write Sequencer

This block is the device-side engine for a control transfer in which the host writes data to endpoint zero. It works at packet level. Token decode, CRC checking and line coding happen upstream. The block receives token events, payload bytes and an end-of-packet marker that carries the data PID and the CRC verdict. After each event that needs an answer, it returns one handshake code or a zero-length DATA1 packet.

On the firmware side the block offers the following:
- an 8-byte setup register bank, read by index;
- a show-ahead receive FIFO with a byte-count register and a data-ready flag;
- two write-one-to-clear interrupt bits and an interrupt line;
- two command strobes.

The first strobe lets the data stage proceed. The second lets the status stage complete. A speed-mode input chooses between the high-speed rules (PING honoured, accepted OUT answered with NYET) and the full-speed rules (PING ignored, accepted OUT answered with ACK).

Each reply appears on `rsp_valid`/`rsp_code` exactly one clock after the cycle of the token or end-of-packet that caused it.

Top module: `ep0_ctrl_write_seq`

## Requirements
- R1: After a SETUP token, a packet of exactly 8 bytes with a DATA0 PID (`rx_pid1`=0) and good CRC is answered with ACK (code 0). Its bytes become readable at `setup_sel` 0..7 in arrival order, and `int_status[0]` is set. A packet of any other length, with a DATA1 PID or with bad CRC gets no reply.
- R2: Until `cmd_setup_rcvd` is pulsed after a stored setup packet, every OUT packet is answered with NAK (code 1) and nothing is delivered. A high-speed PING is also answered with NAK.
- R3: An accepted, error-free OUT packet with the expected PID is answered with NYET (code 2) when `hs_mode`=1 and with ACK when `hs_mode`=0. It sets `data_ready`, sets `int_status[1]` and loads its byte count into `rx_size`.
- R4: An OUT packet that arrives while `data_ready` is high is answered with NAK. The unread FIFO content and `rx_size` stay unchanged.
- R5: When `hs_mode`=1, a PING in the data stage is answered with ACK if no unread data is held and with NAK otherwise. When `hs_mode`=0, a PING gets no reply.
- R6: The first data-stage OUT packet must carry DATA1, and the expected PID alternates after each delivered packet. A packet with the wrong PID receives the normal handshake but is discarded: `data_ready` stays low and the expected PID does not change.
- R7: `fifo_dout` shows the oldest unread byte, and a `fifo_rd` pulse advances it. `data_ready` falls on the clock where the `rx_size`-th byte is read.
- R8: In the status stage, IN is answered with NAK until `cmd_setup_fin` has been pulsed. After that, IN is answered with a zero-length DATA1 packet (code 3). A host ACK (`host_ack`) then ends the transfer, and later IN tokens get no reply.
- R9: A SETUP token at any point aborts the transfer in progress. It clears `data_ready` and empties the FIFO on the next clock, restarts the setup stage and resets the expected data PID to DATA1.
- R10: Writing 1 to a bit of `int_clr` clears that bit of `int_status`. `irq` is the OR of the two bits. Both are 0 after reset, as are `rsp_valid` and `data_ready`.
- R11: An accepted OUT packet with bad CRC gets no reply, delivers nothing and leaves the expected PID unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_mode | input | 1 | 1 = high-speed handshake rules, 0 = full-speed |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token: 0 SETUP, 1 OUT, 2 IN, 3 PING |
| rx_byte_valid | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| rx_end | input | 1 | End of data packet |
| rx_pid1 | input | 1 | Data PID of the ending packet: 1 = DATA1 |
| rx_crc_ok | input | 1 | CRC verdict of the ending packet |
| host_ack | input | 1 | Host handshake ACK received |
| rsp_valid | output | 1 | Reply strobe |
| rsp_code | output | 2 | Reply: 0 ACK, 1 NAK, 2 NYET, 3 zero-length DATA1 |
| setup_sel | input | 3 | Setup byte index |
| setup_byte | output | 8 | Selected setup byte |
| fifo_rd | input | 1 | FIFO pop strobe |
| fifo_dout | output | 8 | Oldest unread FIFO byte |
| rx_size | output | $clog2(FIFO_DEPTH)+1 | Byte count of the delivered packet |
| data_ready | output | 1 | Unread packet held in the FIFO |
| cmd_setup_rcvd | input | 1 | Firmware command: setup consumed |
| cmd_setup_fin | input | 1 | Firmware command: setup finished |
| int_clr | input | 2 | Write-one-to-clear for `int_status` |
| int_status | output | 2 | bit0 setup stored, bit1 OUT data delivered |
| irq | output | 1 | Interrupt line |

## Verification
The checker assumes the following about the inputs:
- Token strobes, payload bytes, end-of-packet markers and host ACKs each occupy their own clock cycles and never coincide.
- `hs_mode` changes only while no reply is pending.
- Firmware pulses `fifo_rd` only while `data_ready` is high.

Under these assumptions, every reply traces back to exactly one event in the previous cycle, and a fall of `data_ready` traces back to a read or a SETUP. The stimulus drives one event per clock on the falling edge. It returns every strobe to 0 before the next event, and it switches speed mode only between transfers.

// File: rtl/ep0cw_pkg.sv
package ep0cw_pkg;
   localparam int SETUP_LEN   = 8;
   localparam int SETUP_SEL_W = $clog2(SETUP_LEN);
   localparam int SETUP_CNT_W = $clog2(SETUP_LEN + 2);

   typedef enum logic [1:0] {
      TK_SETUP = 2'd0,
      TK_OUT   = 2'd1,
      TK_IN    = 2'd2,
      TK_PING  = 2'd3
   } tok_e;

   typedef enum logic [1:0] {
      RC_ACK  = 2'd0,
      RC_NAK  = 2'd1,
      RC_NYET = 2'd2,
      RC_ZLP1 = 2'd3
   } rsp_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_HOLD,
      ST_DATA,
      ST_STATUS,
      ST_ZLP
   } stage_e;
endpackage

// File: rtl/ep0cw_setup_bank.sv
module ep0cw_setup_bank
   import ep0cw_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   restart,
   input  logic                   wr_en,
   input  logic [BYTE_W-1:0]      din,
   input  logic [SETUP_SEL_W-1:0] sel,
   output logic [BYTE_W-1:0]      dout,
   output logic [SETUP_CNT_W-1:0] count
);
   localparam logic [SETUP_CNT_W-1:0] CNT_SAT = SETUP_CNT_W'(SETUP_LEN + 1);

   logic [BYTE_W-1:0] bytes_w [SETUP_LEN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          count <= '0;
      else if (restart)                    count <= '0;
      else if (wr_en && count != CNT_SAT)  count <= count + 1'b1;
   end

   for (genvar g = 0; g < SETUP_LEN; g++) begin : g_byte
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   q <= '0;
         else if (wr_en && count == SETUP_CNT_W'(g))   q <= din;
      end
      assign bytes_w[g] = q;
   end

   assign dout = bytes_w[sel];
endmodule

// File: rtl/ep0cw_rx_fifo.sv
module ep0cw_rx_fifo #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic                   wr_en,
   input  logic [DATA_W-1:0]      din,
   input  logic                   rd_en,
   output logic [DATA_W-1:0]      dout,
   output logic [$clog2(DEPTH):0] wr_cnt,
   output logic [$clog2(DEPTH):0] rd_cnt
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ep0cw_rx_fifo: DEPTH must be a power of two, at least 8");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic              room;

   assign room = wr_cnt < CNT_W'(DEPTH);

   always_ff @(posedge clk) begin
      if (wr_en && room && !flush) mem[wr_cnt[PTR_W-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_cnt <= '0;
         rd_cnt <= '0;
      end else if (flush) begin
         wr_cnt <= '0;
         rd_cnt <= '0;
      end else begin
         if (wr_en && room) wr_cnt <= wr_cnt + 1'b1;
         if (rd_en)         rd_cnt <= rd_cnt + 1'b1;
      end
   end

   assign dout = mem[rd_cnt[PTR_W-1:0]];
endmodule

// File: rtl/ep0cw_ctrl.sv
module ep0cw_ctrl
   import ep0cw_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hs_mode,
   input  logic                   tok_valid,
   input  logic [1:0]             tok_kind,
   input  logic                   rx_byte_valid,
   input  logic                   rx_end,
   input  logic                   rx_pid1,
   input  logic                   rx_crc_ok,
   input  logic                   host_ack,
   input  logic                   cmd_setup_rcvd,
   input  logic                   cmd_setup_fin,
   input  logic [1:0]             int_clr,
   input  logic                   fifo_rd,
   input  logic [SETUP_CNT_W-1:0] setup_cnt,
   input  logic [CNT_W-1:0]       wr_cnt,
   input  logic [CNT_W-1:0]       rd_cnt,
   output logic                   setup_restart,
   output logic                   setup_wr,
   output logic                   fifo_flush,
   output logic                   fifo_wr,
   output logic                   fifo_rd_en,
   output logic                   rsp_valid,
   output logic [1:0]             rsp_code,
   output logic                   data_ready,
   output logic [CNT_W-1:0]       rx_size,
   output logic [1:0]             int_status
);
   stage_e     stage;
   logic       cur_out, accept, toggle, fin_seen;
   logic       tok_setup, setup_ok, deliver, last_rd;
   logic [1:0] int_set;
   rsp_e       ok_code;

   assign tok_setup     = tok_valid && tok_kind == TK_SETUP;
   assign setup_ok      = rx_crc_ok && !rx_pid1 && setup_cnt == SETUP_CNT_W'(SETUP_LEN);
   assign deliver       = rx_end && cur_out && accept && rx_crc_ok && rx_pid1 == toggle;
   assign fifo_rd_en    = fifo_rd && data_ready;
   assign last_rd       = fifo_rd_en && CNT_W'(rd_cnt + 1'b1) == rx_size;
   assign setup_restart = tok_setup;
   assign setup_wr      = rx_byte_valid && stage == ST_SETUP;
   assign fifo_wr       = rx_byte_valid && cur_out && accept;
   assign fifo_flush    = tok_setup || last_rd || (rx_end && cur_out && accept && !deliver);
   assign ok_code       = hs_mode ? RC_NYET : RC_ACK;
   assign int_set       = {deliver, rx_end && stage == ST_SETUP && setup_ok};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_status <= '0;
      else        int_status <= (int_status & ~int_clr) | int_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage      <= ST_IDLE;
         cur_out    <= 1'b0;
         accept     <= 1'b0;
         toggle     <= 1'b1;
         fin_seen   <= 1'b0;
         data_ready <= 1'b0;
         rx_size    <= '0;
         rsp_valid  <= 1'b0;
         rsp_code   <= RC_ACK;
      end else if (tok_setup) begin
         stage      <= ST_SETUP;
         cur_out    <= 1'b0;
         accept     <= 1'b0;
         toggle     <= 1'b1;
         fin_seen   <= 1'b0;
         data_ready <= 1'b0;
         rx_size    <= '0;
         rsp_valid  <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         if (tok_valid) begin
            case (tok_kind)
               TK_OUT: begin
                  cur_out <= stage == ST_DATA || stage == ST_HOLD;
                  accept  <= stage == ST_DATA && !data_ready;
               end
               TK_PING: begin
                  if (hs_mode && (stage == ST_DATA || stage == ST_HOLD)) begin
                     rsp_valid <= 1'b1;
                     rsp_code  <= (stage == ST_DATA && !data_ready) ? RC_ACK : RC_NAK;
                  end
               end
               TK_IN: begin
                  if (stage inside {ST_HOLD, ST_DATA, ST_STATUS, ST_ZLP}) begin
                     rsp_valid <= 1'b1;
                     cur_out   <= 1'b0;
                     if (fin_seen) begin
                        rsp_code <= RC_ZLP1;
                        stage    <= ST_ZLP;
                     end else begin
                        rsp_code <= RC_NAK;
                        if (stage != ST_HOLD) stage <= ST_STATUS;
                     end
                  end
               end
               default: ;
            endcase
         end
         if (rx_end) begin
            if (stage == ST_SETUP) begin
               if (setup_ok) begin
                  rsp_valid <= 1'b1;
                  rsp_code  <= RC_ACK;
                  stage     <= ST_HOLD;
               end else begin
                  stage <= ST_IDLE;
               end
            end else if (cur_out) begin
               cur_out <= 1'b0;
               if (!accept) begin
                  rsp_valid <= 1'b1;
                  rsp_code  <= RC_NAK;
               end else if (rx_crc_ok) begin
                  rsp_valid <= 1'b1;
                  rsp_code  <= ok_code;
                  if (deliver) begin
                     toggle     <= ~toggle;
                     rx_size    <= wr_cnt;
                     data_ready <= wr_cnt != '0;
                  end
               end
            end
         end
         if (cmd_setup_rcvd && stage == ST_HOLD) stage <= ST_DATA;
         if (cmd_setup_fin && (stage == ST_DATA || stage == ST_STATUS)) fin_seen <= 1'b1;
         if (host_ack && stage == ST_ZLP) stage <= ST_IDLE;
         if (last_rd) data_ready <= 1'b0;
      end
   end
endmodule

// File: rtl/ep0_ctrl_write_seq.sv
module ep0_ctrl_write_seq
   import ep0cw_pkg::*;
#(
   parameter int FIFO_DEPTH = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hs_mode,
   input  logic                        tok_valid,
   input  logic [1:0]                  tok_kind,
   input  logic                        rx_byte_valid,
   input  logic [7:0]                  rx_byte,
   input  logic                        rx_end,
   input  logic                        rx_pid1,
   input  logic                        rx_crc_ok,
   input  logic                        host_ack,
   output logic                        rsp_valid,
   output logic [1:0]                  rsp_code,
   input  logic [2:0]                  setup_sel,
   output logic [7:0]                  setup_byte,
   input  logic                        fifo_rd,
   output logic [7:0]                  fifo_dout,
   output logic [$clog2(FIFO_DEPTH):0] rx_size,
   output logic                        data_ready,
   input  logic                        cmd_setup_rcvd,
   input  logic                        cmd_setup_fin,
   input  logic [1:0]                  int_clr,
   output logic [1:0]                  int_status,
   output logic                        irq
);
   localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

   logic                   setup_restart, setup_wr;
   logic                   fifo_flush, fifo_wr, fifo_rd_en;
   logic [SETUP_CNT_W-1:0] setup_cnt;
   logic [CNT_W-1:0]       wr_cnt, rd_cnt;

   ep0cw_setup_bank #(.BYTE_W(8)) i_setup (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (setup_restart),
      .wr_en   (setup_wr),
      .din     (rx_byte),
      .sel     (setup_sel),
      .dout    (setup_byte),
      .count   (setup_cnt)
   );

   ep0cw_rx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) i_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (fifo_flush),
      .wr_en  (fifo_wr),
      .din    (rx_byte),
      .rd_en  (fifo_rd_en),
      .dout   (fifo_dout),
      .wr_cnt (wr_cnt),
      .rd_cnt (rd_cnt)
   );

   ep0cw_ctrl #(.CNT_W(CNT_W)) i_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .hs_mode        (hs_mode),
      .tok_valid      (tok_valid),
      .tok_kind       (tok_kind),
      .rx_byte_valid  (rx_byte_valid),
      .rx_end         (rx_end),
      .rx_pid1        (rx_pid1),
      .rx_crc_ok      (rx_crc_ok),
      .host_ack       (host_ack),
      .cmd_setup_rcvd (cmd_setup_rcvd),
      .cmd_setup_fin  (cmd_setup_fin),
      .int_clr        (int_clr),
      .fifo_rd        (fifo_rd),
      .setup_cnt      (setup_cnt),
      .wr_cnt         (wr_cnt),
      .rd_cnt         (rd_cnt),
      .setup_restart  (setup_restart),
      .setup_wr       (setup_wr),
      .fifo_flush     (fifo_flush),
      .fifo_wr        (fifo_wr),
      .fifo_rd_en     (fifo_rd_en),
      .rsp_valid      (rsp_valid),
      .rsp_code       (rsp_code),
      .data_ready     (data_ready),
      .rx_size        (rx_size),
      .int_status     (int_status)
   );

   assign irq = |int_status;
endmodule

// File: rtl/ep0cw_checker.sv
module ep0cw_checker
   import ep0cw_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hs_mode,
   input logic             tok_valid,
   input logic [1:0]       tok_kind,
   input logic             fifo_rd,
   input logic             rsp_valid,
   input logic [1:0]       rsp_code,
   input logic             data_ready,
   input logic [CNT_W-1:0] rx_size,
   input logic [1:0]       int_status
);
   // R1: a fresh setup interrupt always comes with an ACK reply
   assert_setup_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_status[0]) |-> (rsp_valid && rsp_code == RC_ACK));

   // R3: full-speed mode never produces NYET
   assert_fs_no_nyet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_code == RC_NYET && !hs_mode));

   // R3: a held packet always has a nonzero byte count
   assert_ready_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready |-> rx_size != '0);

   // R5: full-speed PING is never answered
   assert_fs_ping_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_kind == TK_PING && !hs_mode) |=> !rsp_valid);

   // R7, R9: data_ready drops only after a read or a SETUP token
   assert_ready_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_ready) |-> ($past(fifo_rd) || $past(tok_valid && tok_kind == TK_SETUP)));
endmodule

bind ep0_ctrl_write_seq ep0cw_checker #(.CNT_W($clog2(FIFO_DEPTH) + 1)) i_ep0cw_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .hs_mode    (hs_mode),
   .tok_valid  (tok_valid),
   .tok_kind   (tok_kind),
   .fifo_rd    (fifo_rd),
   .rsp_valid  (rsp_valid),
   .rsp_code   (rsp_code),
   .data_ready (data_ready),
   .rx_size    (rx_size),
   .int_status (int_status)
);

// File: tb/test_ep0_ctrl_write_seq.sv
`timescale 1ns/1ps
module test_ep0_ctrl_write_seq;
   localparam int DEPTH = 64;
   localparam int CW    = $clog2(DEPTH) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hs_mode = 1'b1;
   logic          tok_valid = 1'b0;
   logic [1:0]    tok_kind = 2'd0;
   logic          rx_byte_valid = 1'b0;
   logic [7:0]    rx_byte = 8'd0;
   logic          rx_end = 1'b0, rx_pid1 = 1'b0, rx_crc_ok = 1'b1;
   logic          host_ack = 1'b0;
   logic          rsp_valid;
   logic [1:0]    rsp_code;
   logic [2:0]    setup_sel = 3'd0;
   logic [7:0]    setup_byte;
   logic          fifo_rd = 1'b0;
   logic [7:0]    fifo_dout;
   logic [CW-1:0] rx_size;
   logic          data_ready;
   logic          cmd_setup_rcvd = 1'b0, cmd_setup_fin = 1'b0;
   logic [1:0]    int_clr = 2'd0;
   logic [1:0]    int_status;
   logic          irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   ep0_ctrl_write_seq #(.FIFO_DEPTH(DEPTH)) i_ep0_ctrl_write_seq (
      .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode),
      .tok_valid(tok_valid), .tok_kind(tok_kind),
      .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
      .rx_end(rx_end), .rx_pid1(rx_pid1), .rx_crc_ok(rx_crc_ok),
      .host_ack(host_ack), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
      .setup_sel(setup_sel), .setup_byte(setup_byte),
      .fifo_rd(fifo_rd), .fifo_dout(fifo_dout), .rx_size(rx_size),
      .data_ready(data_ready), .cmd_setup_rcvd(cmd_setup_rcvd),
      .cmd_setup_fin(cmd_setup_fin), .int_clr(int_clr),
      .int_status(int_status), .irq(irq)
   );

   // Token codes and reply codes as stated in the requirements
   localparam logic [1:0] K_SETUP = 2'd0, K_OUT = 2'd1, K_IN = 2'd2, K_PING = 2'd3;
   localparam logic [1:0] C_ACK = 2'd0, C_NAK = 2'd1, C_NYET = 2'd2, C_ZLP = 2'd3;

   // Vector layout: op, arg, pid1, crc_ok, expect reply, expected code, packet ref, requirement
   localparam logic [2:0] OP_TOK = 3'd0, OP_PKT = 3'd1, OP_RCVD = 3'd2, OP_FIN = 3'd3,
                          OP_HACK = 3'd4, OP_READ = 3'd5, OP_RDY = 3'd6;
   localparam int NV = 26;
   localparam logic [24:0] VEC [NV] = '{
      {OP_TOK,  8'd0, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd1},  //  0 R1 SETUP token
      {OP_PKT,  8'd8, 1'b0, 1'b1, 1'b1, C_ACK,  5'd0,  4'd1},  //  1 R1 setup data ACK
      {OP_TOK,  8'd1, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd2},  //  2 R2 OUT before command
      {OP_PKT,  8'd4, 1'b1, 1'b1, 1'b1, C_NAK,  5'd0,  4'd2},  //  3 R2 NAK
      {OP_TOK,  8'd3, 1'b0, 1'b1, 1'b1, C_NAK,  5'd0,  4'd2},  //  4 R2 PING NAK
      {OP_RCVD, 8'd0, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd2},  //  5 R2 command
      {OP_TOK,  8'd3, 1'b0, 1'b1, 1'b1, C_ACK,  5'd0,  4'd5},  //  6 R5 PING ready
      {OP_TOK,  8'd1, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd3},  //  7 R3 OUT
      {OP_PKT,  8'd5, 1'b1, 1'b1, 1'b1, C_NYET, 5'd0,  4'd3},  //  8 R3 NYET
      {OP_RDY,  8'd1, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd3},  //  9 R3 ready set
      {OP_TOK,  8'd3, 1'b0, 1'b1, 1'b1, C_NAK,  5'd0,  4'd5},  // 10 R5 PING busy
      {OP_TOK,  8'd1, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd4},  // 11 R4 OUT while held
      {OP_PKT,  8'd3, 1'b0, 1'b1, 1'b1, C_NAK,  5'd0,  4'd4},  // 12 R4 NAK
      {OP_READ, 8'd5, 1'b0, 1'b1, 1'b0, C_ACK,  5'd8,  4'd7},  // 13 R7 read, R4 content intact
      {OP_RDY,  8'd0, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd7},  // 14 R7 ready cleared
      {OP_TOK,  8'd1, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd6},  // 15 R6 OUT
      {OP_PKT,  8'd3, 1'b1, 1'b1, 1'b1, C_NYET, 5'd0,  4'd6},  // 16 R6 wrong PID
      {OP_RDY,  8'd0, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd6},  // 17 R6 discarded
      {OP_TOK,  8'd1, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd6},  // 18 R6 OUT
      {OP_PKT,  8'd6, 1'b0, 1'b1, 1'b1, C_NYET, 5'd0,  4'd6},  // 19 R6 DATA0 accepted
      {OP_READ, 8'd6, 1'b0, 1'b1, 1'b0, C_ACK,  5'd19, 4'd6},  // 20 R6 content
      {OP_TOK,  8'd2, 1'b0, 1'b1, 1'b1, C_NAK,  5'd0,  4'd8},  // 21 R8 IN before fin
      {OP_FIN,  8'd0, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd8},  // 22 R8 fin command
      {OP_TOK,  8'd2, 1'b0, 1'b1, 1'b1, C_ZLP,  5'd0,  4'd8},  // 23 R8 ZLP
      {OP_HACK, 8'd0, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd8},  // 24 R8 host ACK
      {OP_TOK,  8'd2, 1'b0, 1'b1, 1'b0, C_ACK,  5'd0,  4'd8}   // 25 R8 idle IN silent
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_tok(input logic [1:0] k);
      tok_valid = 1'b1; tok_kind = k;
      @(negedge clk);
      tok_valid = 1'b0;
   endtask

   task automatic do_pkt(input int len, input logic [7:0] base, input logic p1, input logic ok);
      for (int i = 0; i < len; i++) begin
         rx_byte_valid = 1'b1; rx_byte = base + 8'(i);
         @(negedge clk);
      end
      rx_byte_valid = 1'b0;
      rx_end = 1'b1; rx_pid1 = p1; rx_crc_ok = ok;
      @(negedge clk);
      rx_end = 1'b0; rx_crc_ok = 1'b1;
   endtask

   task automatic pulse_rcvd();
      cmd_setup_rcvd = 1'b1; @(negedge clk); cmd_setup_rcvd = 1'b0;
   endtask

   task automatic chk_rsp(input bit ev, input logic [1:0] ec, input string tag);
      if (ev) check(rsp_valid && rsp_code == ec, tag, {rsp_valid, rsp_code}, {1'b1, ec});
      else    check(!rsp_valid, tag, {rsp_valid, rsp_code}, 0);
   endtask

   task automatic read_all(input int len, input logic [7:0] base, input string tag);
      check(rx_size == CW'(len), tag, rx_size, len);
      for (int i = 0; i < len; i++) begin
         check(fifo_dout == base + 8'(i), tag, fifo_dout, base + 8'(i));
         fifo_rd = 1'b1; @(negedge clk); fifo_rd = 1'b0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(!rsp_valid, "R10", rsp_valid, 0);
      check(!data_ready, "R10", data_ready, 0);
      check(int_status == 2'b00, "R10", int_status, 0);
      check(!irq, "R10", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         logic [2:0] op;  logic [7:0] arg;  logic p1, ok, ev;
         logic [1:0] ec;  logic [4:0] rf;   logic [3:0] rq;
         string tag;
         {op, arg, p1, ok, ev, ec, rf, rq} = VEC[v];
         tag = $sformatf("R%0d vec %0d", rq, v);
         case (op)
            OP_TOK:  begin do_tok(arg[1:0]); chk_rsp(ev, ec, tag); end
            OP_PKT:  begin do_pkt(int'(arg), 8'(v * 8), p1, ok); chk_rsp(ev, ec, tag); end
            OP_RCVD: pulse_rcvd();
            OP_FIN:  begin cmd_setup_fin = 1'b1; @(negedge clk); cmd_setup_fin = 1'b0; end
            OP_HACK: begin host_ack = 1'b1; @(negedge clk); host_ack = 1'b0; end
            OP_READ: read_all(int'(arg), 8'(int'(rf) * 8), tag);
            OP_RDY:  check(data_ready == arg[0], tag, data_ready, arg[0]);
            default: ;
         endcase
      end

      // R10 write-one-to-clear, one bit at a time
      check(int_status == 2'b11, "R10 both set", int_status, 3);
      int_clr = 2'b10; @(negedge clk); int_clr = 2'b00;
      check(int_status == 2'b01 && irq, "R10 clear bit1", {irq, int_status}, 5);
      int_clr = 2'b01; @(negedge clk); int_clr = 2'b00;
      check(int_status == 2'b00 && !irq, "R10 clear bit0", {irq, int_status}, 0);

      // R1 setup bytes readable in order
      do_tok(K_SETUP);
      do_pkt(8, 8'hA0, 1'b0, 1'b1);
      chk_rsp(1'b1, C_ACK, "R1 setup ack");
      check(int_status == 2'b01, "R1 setup int", int_status, 1);
      for (int i = 0; i < 8; i++) begin
         setup_sel = 3'(i); #1;
         check(setup_byte == 8'hA0 + 8'(i), "R1 setup byte", setup_byte, 8'hA0 + i);
      end
      int_clr = 2'b01; @(negedge clk); int_clr = 2'b00;

      // R1 malformed setup packets get no reply
      do_tok(K_SETUP); do_pkt(7, 8'h30, 1'b0, 1'b1);
      chk_rsp(1'b0, C_ACK, "R1 short setup");
      do_tok(K_SETUP); do_pkt(8, 8'h30, 1'b1, 1'b1);
      chk_rsp(1'b0, C_ACK, "R1 DATA1 setup");
      do_tok(K_SETUP); do_pkt(8, 8'h30, 1'b0, 1'b0);
      chk_rsp(1'b0, C_ACK, "R1 bad CRC setup");
      check(int_status == 2'b00, "R1 no int", int_status, 0);

      // R11 bad CRC OUT, then R9 abort
      do_tok(K_SETUP); do_pkt(8, 8'h50, 1'b0, 1'b1);
      chk_rsp(1'b1, C_ACK, "R9 setup");
      pulse_rcvd();
      do_tok(K_OUT); do_pkt(4, 8'h60, 1'b1, 1'b0);
      chk_rsp(1'b0, C_ACK, "R11 bad CRC silent");
      check(!data_ready, "R11 nothing delivered", data_ready, 0);
      do_tok(K_OUT); do_pkt(4, 8'h60, 1'b1, 1'b1);
      chk_rsp(1'b1, C_NYET, "R11 DATA1 still expected");
      check(data_ready && rx_size == CW'(4), "R3 size", rx_size, 4);
      do_tok(K_SETUP);
      check(!data_ready, "R9 abort clears ready", data_ready, 0);
      do_pkt(8, 8'h70, 1'b0, 1'b1);
      chk_rsp(1'b1, C_ACK, "R9 restarted setup");
      pulse_rcvd();
      do_tok(K_OUT); do_pkt(2, 8'h90, 1'b1, 1'b1);
      chk_rsp(1'b1, C_NYET, "R9 toggle reset to DATA1");
      read_all(2, 8'h90, "R9 FIFO holds only new data");
      check(!data_ready, "R7 ready cleared", data_ready, 0);

      // R3 and R5 in full-speed mode
      hs_mode = 1'b0;
      do_tok(K_SETUP); do_pkt(8, 8'h11, 1'b0, 1'b1);
      chk_rsp(1'b1, C_ACK, "R3 fs setup");
      pulse_rcvd();
      do_tok(K_PING);
      chk_rsp(1'b0, C_ACK, "R5 fs PING silent");
      int_clr = 2'b11; @(negedge clk); int_clr = 2'b00;
      do_tok(K_OUT); do_pkt(3, 8'hC0, 1'b1, 1'b1);
      chk_rsp(1'b1, C_ACK, "R3 fs ACK");
      check(int_status[1] && rx_size == CW'(3), "R3 fs size and int", rx_size, 3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule